// File: doc/BRIEF.md
# Clock Fan-out Enable and Power-down Controller

This block is the control logic of a buffer that fans one differential clock out to ten differential output pairs and one feedback pair. It runs on a free-running housekeeping clock. It samples the levels of the true and complement input clock lines, an asynchronous output-enable pin, an output-select strap and a flag that says whether the PLL supply is present. From these it produces an enable for each output pair and for the feedback pair, along with PLL-on and PLL-bypass controls, a stabilizing flag and a flag for the reserved input state.

When the inputs sit low together long enough to cover one slow input period, the block treats this as a request for low power. It then switches off every output and the PLL. Leaving power-down needs an edge on the true input while the both-low condition is gone. After that, the feedback pair comes back at once, and the clock pairs stay dark for a fixed lock-wait time so the PLL can reach phase lock. A disabled pair has its enable low, and the output driver holds both of its lines low.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: `pair_en[i]` enables output pair i, for i = 0 to 9. `fb_en` enables the feedback pair. In the running state with `out_en`=1, all ten bits of `pair_en` are 1.
- R2: In the running state with `out_en`=0 and `sel_strap`=1, `pair_en` is all zero, while `fb_en` stays 1 and `pll_on` keeps following the supply flag. `out_en` acts on `pair_en` combinationally, with no cycle of delay.
- R3: With `sel_strap`=0, pair 7 (`pair_en[7]`) ignores `out_en` and stays enabled whenever the block is running. The other pairs still follow `out_en`.
- R4: `pll_bypass` equals the inverse of `pll_supply_ok`. `pll_on` is 1 only when the supply is present and the block is not powered down. The supply flag has no effect on the pair enables.
- R5: Suppose both inputs change to low just after a rising edge of the housekeeping clock. With `LOW_DET_CYCLES`=L, the enables are still on after 2+L rising edges and are all off after 3+L. In power-down, `pair_en`, `fb_en` and `pll_on` are 0 whatever the values of `out_en`, `sel_strap` and `pll_supply_ok`.
- R6: With both inputs high, `reserved_err` reads 1 two rising edges later, and the enables do not change.
- R7: Power-down is left only after a rising or falling edge on the synchronized true input while the inputs are not both low. In the lock-wait that follows, `stabilizing`=1, `fb_en`=1 and `pair_en`=0. A high complement with a quiet true input does not wake the block.
- R8: The lock-wait lasts `LOCK_CYCLES` housekeeping cycles. The state changes to running 3+`LOCK_CYCLES` rising edges after the true input rises.
- R9: While `rst_n` is low at a rising edge, the block goes to power-down with every enable, `pll_on` and `stabilizing` at 0.
- R10: If the inputs sit both-low for L cycles during the lock-wait, the block returns to power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running housekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_true | input | 1 | Level of the true input clock line |
| in_comp | input | 1 | Level of the complement input clock line |
| out_en | input | 1 | Asynchronous output-enable pin |
| sel_strap | input | 1 | Output-select strap; 0 frees pair 7 from `out_en` |
| pll_supply_ok | input | 1 | 1 when the PLL supply is present |
| pair_en | output | 10 | Per-pair output enable, bit i is pair i |
| fb_en | output | 1 | Feedback pair enable |
| pll_on | output | 1 | PLL power control |
| pll_bypass | output | 1 | Routes the input clock around the PLL |
| stabilizing | output | 1 | High during the lock-wait |
| reserved_err | output | 1 | Both inputs seen high |

## Verification
The assertions check, on every cycle, that no pair is enabled while the feedback pair is off, that the lock-wait never lets a pair through, that the free pair stays on while running with the strap low, and that bypass and PLL-on never overlap. They also check that power-down follows only a both-low history and that running is reached only after a full lock count. Only the bench scenarios show the exact edge on which power-down is declared and on which the lock-wait ends. They also show that a complement-only change does not wake the block, that a both-low during lock-wait aborts it, and that the enable table holds across random pin patterns.

// File: rtl/cfo_pkg.sv
// Shared types for the clock fan-out controller.
// Assumes: three control states are enough (off, waiting for lock, running).
package cfo_pkg;
    typedef enum logic [1:0] {
        ST_PDOWN    = 2'd0,
        ST_LOCKWAIT = 2'd1,
        ST_RUN      = 2'd2
    } cfo_state_e;
endpackage

// File: rtl/cfo_sync.sv
// Two-flop synchronizer bank for level inputs from another clock domain.
// Assumes: each bit is an independent level, so no bus coherence is needed.
module cfo_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit; reset puts both to low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfo_lowdet.sv
// Input level detector: counts how long the two synchronized input lines
// have both been low, detects edges on the true line, and flags the
// reserved both-high state.
// Assumes: inputs are already synchronized to clk.
module cfo_lowdet #(
    parameter int LOW_DET_CYCLES = 4,
    localparam int CW = $clog2(LOW_DET_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic t_s,
    input  logic c_s,
    output logic both_low,
    output logic both_high,
    output logic pd_req,
    output logic true_edge
);
    logic [CW-1:0] low_cnt;
    logic          t_prev;

    assign both_low  = !t_s && !c_s;
    assign both_high = t_s && c_s;
    assign pd_req    = (low_cnt == CW'(LOW_DET_CYCLES));
    assign true_edge = t_s ^ t_prev;

    // Saturating count of consecutive both-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_cnt <= '0;
        else if (!both_low) low_cnt <= '0;
        else if (!pd_req)   low_cnt <= low_cnt + 1'b1;
    end

    // Previous true level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) t_prev <= 1'b0;
        else        t_prev <= t_s;
    end

    // R5: a power-down request only follows a both-low cycle.
    p_pd_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req && $past(rst_n) |-> $past(both_low));
endmodule

// File: rtl/cfo_seq.sv
// Power sequencer: power-down, lock-wait and running states, with a
// lock-wait counter.
// Assumes: pd_req and wake come from the level detector in the same domain.
module cfo_seq
    import cfo_pkg::*;
#(
    parameter int LOCK_CYCLES = 1500,
    localparam int LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       wake,
    output cfo_state_e state
);
    logic [LW-1:0] lock_cnt;
    logic          lock_done;

    assign lock_done = (lock_cnt == LW'(LOCK_CYCLES - 1));

    // State transitions: a power-down request wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PDOWN;
        end else begin
            unique case (state)
                ST_PDOWN:    if (wake) state <= ST_LOCKWAIT;
                ST_LOCKWAIT: if (pd_req) state <= ST_PDOWN;
                             else if (lock_done) state <= ST_RUN;
                ST_RUN:      if (pd_req) state <= ST_PDOWN;
                default:     state <= ST_PDOWN;
            endcase
        end
    end

    // Lock-wait counter: cleared outside the wait, counts up inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_LOCKWAIT) lock_cnt <= '0;
        else if (!lock_done)                lock_cnt <= lock_cnt + 1'b1;
    end

    // R8: running is entered only after the full lock count.
    p_lock_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN && $past(state) != ST_RUN && $past(rst_n)
        |-> $past(lock_done));

    // R10: a request in lock-wait returns to power-down.
    p_wait_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOCKWAIT && pd_req |=> state == ST_PDOWN);
endmodule

// File: rtl/clk_fanout_ctrl.sv
// Control logic for a one-to-N differential clock fan-out buffer.
// Synchronizes the input line levels, detects power-down and wake, sequences
// the lock-wait, and decodes per-pair enables from the enable pin and strap.
// Assumes: out_en and sel_strap act combinationally on the enables (they are
// static or asynchronous pins); rst_n is synchronous active-low.
module clk_fanout_ctrl
    import cfo_pkg::*;
#(
    parameter int NUM_PAIRS      = 10,
    parameter int FREE_PAIR      = 7,
    parameter int LOW_DET_CYCLES = 4,
    parameter int LOCK_CYCLES    = 1500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_true,
    input  logic                 in_comp,
    input  logic                 out_en,
    input  logic                 sel_strap,
    input  logic                 pll_supply_ok,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic                 fb_en,
    output logic                 pll_on,
    output logic                 pll_bypass,
    output logic                 stabilizing,
    output logic                 reserved_err
);
    logic [1:0] lvl_s;
    logic       both_low, both_high, pd_req, true_edge;
    cfo_state_e state;
    logic       running;

    cfo_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({in_true, in_comp}), .q(lvl_s)
    );

    cfo_lowdet #(.LOW_DET_CYCLES(LOW_DET_CYCLES)) u_lowdet (
        .clk(clk), .rst_n(rst_n),
        .t_s(lvl_s[1]), .c_s(lvl_s[0]),
        .both_low(both_low), .both_high(both_high),
        .pd_req(pd_req), .true_edge(true_edge)
    );

    cfo_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pd_req(pd_req), .wake(true_edge && !both_low),
        .state(state)
    );

    assign running      = (state == ST_RUN);
    assign fb_en        = (state != ST_PDOWN);
    assign stabilizing  = (state == ST_LOCKWAIT);
    assign pll_bypass   = !pll_supply_ok;
    assign pll_on       = pll_supply_ok && (state != ST_PDOWN);
    assign reserved_err = both_high;

    // Per-pair enable decode; the free pair is exempt when the strap is low.
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        if (i == FREE_PAIR) begin : g_free
            assign pair_en[i] = running && (out_en || !sel_strap);
        end else begin : g_gated
            assign pair_en[i] = running && out_en;
        end
    end

    // R5: no clock pair is on while the feedback pair is off.
    p_pd_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_en |-> pair_en == '0 && !pll_on);

    // R7: during lock-wait pairs stay dark and feedback is on.
    p_wait_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stabilizing |-> pair_en == '0 && fb_en);

    // R3: free pair runs whenever running with the strap low.
    p_free_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running && !sel_strap |-> pair_en[FREE_PAIR]);

    // R4: bypass and PLL-on never overlap.
    p_bypass_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> !pll_on);
endmodule

// File: tb/clk_fanout_ctrl_tb_top.sv
module clk_fanout_ctrl_tb_top;
    localparam int NP   = 10;
    localparam int FREE = 7;
    localparam int L    = 4;
    localparam int LOCK = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_true = 1'b0, in_comp = 1'b0;
    logic out_en = 1'b1, sel_strap = 1'b1, pll_supply_ok = 1'b1;
    logic [NP-1:0] pair_en;
    logic fb_en, pll_on, pll_bypass, stabilizing, reserved_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clk_fanout_ctrl #(.NUM_PAIRS(NP), .FREE_PAIR(FREE),
                      .LOW_DET_CYCLES(L), .LOCK_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_true(in_true), .in_comp(in_comp),
        .out_en(out_en), .sel_strap(sel_strap), .pll_supply_ok(pll_supply_ok),
        .pair_en(pair_en), .fb_en(fb_en), .pll_on(pll_on),
        .pll_bypass(pll_bypass), .stabilizing(stabilizing),
        .reserved_err(reserved_err)
    );

    function automatic logic [NP-1:0] exp_pairs(input logic oe, input logic sel);
        logic [NP-1:0] v;
        v = oe ? {NP{1'b1}} : '0;
        if (!sel) v[FREE] = 1'b1;
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R9: reset state
        chk("R9 pair_en", pair_en, 0);
        chk("R9 fb_en", fb_en, 0);
        chk("R9 pll_on", pll_on, 0);
        chk("R9 stabilizing", stabilizing, 0);

        // R7: complement alone does not wake
        in_comp = 1'b1;
        tick(10);
        chk("R7 no wake on comp", {fb_en, stabilizing}, 0);

        // R7/R8: true edge wakes, lock-wait timing
        in_true = 1'b1; in_comp = 1'b0;
        tick(3);
        chk("R7 stabilizing", stabilizing, 1);
        chk("R7 fb_en", fb_en, 1);
        chk("R7 pairs dark", pair_en, 0);
        tick(LOCK - 1);
        chk("R8 still waiting", stabilizing, 1);
        tick(1);
        chk("R8 running", {stabilizing, fb_en}, 2'b01);
        chk("R1 all pairs on", pair_en, {NP{1'b1}});

        // R1-R4: random pin patterns while running
        for (int k = 0; k < 300; k++) begin
            out_en = 1'($urandom); sel_strap = 1'($urandom);
            pll_supply_ok = 1'($urandom);
            #1;
            if (!out_en && !sel_strap) chk("R3 free pair", pair_en, exp_pairs(out_en, sel_strap));
            else if (!out_en) chk("R2 oe low", pair_en, exp_pairs(out_en, sel_strap));
            else chk("R1 oe high", pair_en, exp_pairs(out_en, sel_strap));
            chk("R2 fb stays", fb_en, 1);
            chk("R4 pll_on", pll_on, pll_supply_ok);
            chk("R4 bypass", pll_bypass, !pll_supply_ok);
            tick(1);
        end
        out_en = 1'b1; sel_strap = 1'b1; pll_supply_ok = 1'b1;

        // R6: reserved both-high
        in_comp = 1'b1;
        tick(2);
        chk("R6 reserved flag", reserved_err, 1);
        chk("R6 pairs unchanged", pair_en, {NP{1'b1}});
        in_comp = 1'b0;
        tick(2);
        chk("R6 flag clears", reserved_err, 0);

        // R5: power-down boundary
        in_true = 1'b0;
        tick(2 + L);
        chk("R5 not yet down", pair_en, {NP{1'b1}});
        tick(1);
        chk("R5 down pairs", pair_en, 0);
        chk("R5 down fb/pll", {fb_en, pll_on}, 0);
        out_en = 1'b1; sel_strap = 1'b0; pll_supply_ok = 1'b1;
        #1;
        chk("R5 pins ignored", {pair_en, fb_en, pll_on}, 0);
        sel_strap = 1'b1;

        // R10: both-low during lock-wait aborts
        in_true = 1'b1;
        tick(3);
        chk("R10 in wait", stabilizing, 1);
        in_true = 1'b0;
        tick(3 + L);
        chk("R10 back down", {stabilizing, fb_en}, 0);

        // R4: bypass with supply absent in power-down
        pll_supply_ok = 1'b0;
        #1;
        chk("R4 bypass down", {pll_bypass, pll_on}, 2'b10);

        summary();
    end
endmodule